// File: doc/BRIEF.md
# Programmable Jam-Preset Frequency Divider

This block divides its clock by a programmable ratio N and gives one output pulse per N clocks. N comes from a 16-bit jam word that holds BCD digits. A three-bit mode select chooses the modulus of a fast prescaling section: 2, 4, 5, 8 or 10. The low nibble of the jam word is split between that fast section and a small binary top section, and the split depends on the mode. Three BCD decades sit between the two sections. The counter runs down. When it reaches its terminal state it produces a one-clock pulse and reloads itself from the jam word, so the ratio can be retuned while it runs.

Two extra modes are built in. The first is a hold mode that keeps the counter loaded and frozen. The second is a fixed divide-by-10000 mode that ignores the jam word. A latch input can hold the output high after a pulse until the latch input is released. The block is meant for synthesizer-style channel division, where software or a controller supplies the jam word and the mode.

Top module: `divn_counter`

## Requirements
- R1: In the divide-by-10 mode (modeSel = 3'b110, where modeSel[2], modeSel[1] and modeSel[0] are selectors A, B and C), the output period is N = 10·(100·d4 + 10·d3 + d2) + d1. Here d1 = jam[3:0], d2 = jam[7:4], d3 = jam[11:8] and d4 = jam[15:12].
- R2: In the divide-by-2 mode (modeSel = 3'b111), d1 = jam[0] and the top value t = jam[3:1]. The period is N = 2·(1000·t + 100·d4 + 10·d3 + d2) + d1.
- R3: The divide-by-4 mode (3'b011) uses d1 = jam[1:0] and t = jam[3:2]. The divide-by-5 mode (3'b101) and the divide-by-8 mode (3'b001) use d1 = jam[2:0] and t = jam[3]. In each mode the period is N = M·(1000·t + 100·d4 + 10·d3 + d2) + d1, where M is the mode's modulus.
- R4: At each terminal count, divOut goes high for exactly one clock. In the same cycle the counter reloads from the jam word presented at that moment, so a jam change takes effect from the next period.
- R5: A decade preset of 10 to 15 adds its full binary value × M × place value to the first period. The largest divide-by-8 ratio is therefore 21327 (jam = 16'hFFFF).
- R6: While modeSel[1:0] = 2'b00 (hold mode), the counter stays loaded and divOut gives no pulse. After the mode is left, the first pulse comes N+1 clocks later.
- R7: When latchEn is high at a pulse, divOut rises and stays high until latchEn is sampled low. The latch does not apply in mode 3'b010.
- R8: Mode 3'b010 with latchEn low divides by exactly 10000 and ignores the jam word. Mode 3'b010 with latchEn high behaves as the R1 mode, without latching.
- R9: A synchronous active-high rst clears divOut and puts the counter in the hold-mode load state. The first pulse then comes N+1 clocks after rst is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| jam | input | 16 | Preset word: prescaler/top nibble followed by three BCD decades |
| modeSel | input | 3 | Mode selectors A (bit 2), B (bit 1), C (bit 0) |
| latchEn | input | 1 | Holds the output high after a pulse while high |
| divOut | output | 1 | Divided output pulse |

## Verification
Two functions can fall in the same clock edge: a terminal-count reload and a pulse that latchEn turns into a held level. A second pair is a jam-word change and the reload that picks it up. The bench provokes the first pair by raising and dropping latchEn around pulses in divide-by-5 mode. It provokes the second by rewriting the jam word partway through a divide-by-10 period. A behavioural model tracks the remaining count with a plain integer, takes N from the formula at each reload, applies the latch rule, and is compared with divOut on every clock.

// File: rtl/divn_pkg.sv
`timescale 1ns/1ps
package divn_pkg;

  typedef struct packed {
    logic [3:0] modulus;
    logic [2:0] firstBits;
    logic       fixedLoad;
    logic       master;
    logic       latchOk;
  } mode_cfg_t;

  typedef struct packed {
    logic       load;
    logic       count;
    logic [3:0] modulus;
    logic [2:0] firstBits;
    logic       fixedLoad;
  } dp_strobe_t;

  function automatic mode_cfg_t decodeMode(input logic [2:0] sel, input logic latchIn);
    mode_cfg_t cfg;
    cfg.modulus   = 4'd10;
    cfg.firstBits = 3'd4;
    cfg.fixedLoad = 1'b0;
    cfg.master    = 1'b0;
    cfg.latchOk   = 1'b1;
    case (sel)
      3'b111: begin cfg.modulus = 4'd2; cfg.firstBits = 3'd1; end
      3'b011: begin cfg.modulus = 4'd4; cfg.firstBits = 3'd2; end
      3'b101: begin cfg.modulus = 4'd5; cfg.firstBits = 3'd3; end
      3'b001: begin cfg.modulus = 4'd8; cfg.firstBits = 3'd3; end
      3'b110: ;
      3'b010: begin cfg.fixedLoad = !latchIn; cfg.latchOk = 1'b0; end
      default: cfg.master = 1'b1;
    endcase
    return cfg;
  endfunction

endpackage

// File: rtl/divn_datapath.sv
`timescale 1ns/1ps
module divn_datapath
  import divn_pkg::*;
#(
  parameter int DECADES = 3,
  parameter int TOP_W   = 3,
  localparam int JAM_W  = 4 + 4 * DECADES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [JAM_W-1:0] jam,
  input  dp_strobe_t       strobe,
  output logic             atTerminal,
  output logic             anyNonZero
);

  logic [3:0]                lowCnt, lowNext, lowLoad;
  logic [DECADES-1:0][3:0]   decCnt, decNext, decLoad;
  logic [TOP_W-1:0]          topCnt, topNext, topLoad;
  logic [DECADES:0]          borrow;
  logic [4:0]                lowMask;
  logic                      higherZero;

  // preset split: low nibble shared between prescaler and top section
  always_comb begin
    lowMask = (5'd1 << strobe.firstBits) - 5'd1;
    lowLoad = jam[3:0] & lowMask[3:0];
    topLoad = TOP_W'(jam[3:0] >> strobe.firstBits);
    if (strobe.fixedLoad) begin
      lowLoad = '0;
      topLoad = TOP_W'(1);
    end
  end

  generate
    for (genvar g = 0; g < DECADES; g++) begin : gDecade
      assign decLoad[g] = strobe.fixedLoad ? 4'd0 : jam[4 + 4*g +: 4];
      assign decNext[g] = !borrow[g]       ? decCnt[g] :
                          (decCnt[g] == 4'd0) ? 4'd9 : decCnt[g] - 4'd1;
      assign borrow[g+1] = borrow[g] && (decCnt[g] == 4'd0);
    end
  endgenerate

  assign borrow[0] = (lowCnt == 4'd0);
  assign lowNext   = borrow[0] ? strobe.modulus - 4'd1 : lowCnt - 4'd1;
  assign topNext   = borrow[DECADES] ? topCnt - TOP_W'(1) : topCnt;

  assign higherZero = (decCnt == '0) && (topCnt == '0);
  assign atTerminal = higherZero && (lowCnt <= 4'd1);
  assign anyNonZero = !(higherZero && (lowCnt == 4'd0));

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      lowCnt <= lowLoad;
      decCnt <= decLoad;
      topCnt <= topLoad;
    end else if (strobe.count) begin
      lowCnt <= lowNext;
      decCnt <= decNext;
      topCnt <= topNext;
    end
  end

  // R1
  count_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.count |=> anyNonZero);

  // R8
  fixed_load_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && strobe.fixedLoad) |=> (topCnt == TOP_W'(1) && lowCnt == 4'd0 && decCnt == '0));

endmodule

// File: rtl/divn_ctrl.sv
`timescale 1ns/1ps
module divn_ctrl
  import divn_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] modeSel,
  input  logic       latchEn,
  input  logic       atTerminal,
  output dp_strobe_t strobe,
  output logic       divOut
);

  mode_cfg_t cfg;
  logic      armed, pulseReg, latchReg;
  logic      holdLoad, fire;

  assign cfg      = decodeMode(modeSel, latchEn);
  assign holdLoad = rst || cfg.master || !armed;
  assign fire     = !holdLoad && atTerminal;

  always_comb begin
    strobe.load      = holdLoad || atTerminal;
    strobe.count     = !holdLoad && !atTerminal;
    strobe.modulus   = cfg.modulus;
    strobe.firstBits = cfg.firstBits;
    strobe.fixedLoad = cfg.fixedLoad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      pulseReg <= 1'b0;
      latchReg <= 1'b0;
    end else begin
      armed    <= !cfg.master;
      pulseReg <= fire;
      latchReg <= latchEn && (latchReg || (fire && cfg.latchOk));
    end
  end

  assign divOut = pulseReg || latchReg;

  // R6
  master_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cfg.master |=> (!pulseReg && !armed));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (latchReg && latchEn) |=> latchReg);

  // R4
  pulse_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulseReg) |-> $past(armed));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!divOut && !armed));

endmodule

// File: rtl/divn_counter.sv
`timescale 1ns/1ps
module divn_counter
  import divn_pkg::*;
#(
  parameter int DECADES = 3,
  parameter int TOP_W   = 3,
  localparam int JAM_W  = 4 + 4 * DECADES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [JAM_W-1:0] jam,
  input  logic [2:0]       modeSel,
  input  logic             latchEn,
  output logic             divOut
);

  dp_strobe_t strobe;
  logic       atTerminal;
  logic       anyNonZero;

  divn_ctrl ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .modeSel    (modeSel),
    .latchEn    (latchEn),
    .atTerminal (atTerminal),
    .strobe     (strobe),
    .divOut     (divOut)
  );

  divn_datapath #(.DECADES(DECADES), .TOP_W(TOP_W)) dp_i (
    .clk        (clk),
    .rst        (rst),
    .jam        (jam),
    .strobe     (strobe),
    .atTerminal (atTerminal),
    .anyNonZero (anyNonZero)
  );

endmodule

// File: tb/divn_counter_tb.sv
`timescale 1ns/1ps
module divn_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] jam = '0;
  logic [2:0]  modeSel = 3'b000;
  logic        latchEn = 1'b0;
  logic        divOut;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string tag    = "R9";

  int mRem = 0;
  bit mArmed = 0, mPulse = 0, mLatch = 0;

  divn_counter dut_i (
    .clk(clk), .rst(rst), .jam(jam), .modeSel(modeSel),
    .latchEn(latchEn), .divOut(divOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ratioOf(input logic [15:0] j, input logic [2:0] s, input logic el);
    int m, d1, t, mid;
    mid = 100 * int'(j[15:12]) + 10 * int'(j[11:8]) + int'(j[7:4]);
    m = 10; d1 = int'(j[3:0]); t = 0;
    case (s)
      3'b111: begin m = 2; d1 = int'(j[0]);   t = int'(j[3:1]); end
      3'b011: begin m = 4; d1 = int'(j[1:0]); t = int'(j[3:2]); end
      3'b101: begin m = 5; d1 = int'(j[2:0]); t = int'(j[3]);   end
      3'b001: begin m = 8; d1 = int'(j[2:0]); t = int'(j[3]);   end
      3'b010: if (!el) return 10000;
      default: ;
    endcase
    return m * (1000 * t + mid) + d1;
  endfunction

  // reference model, updated at each rising edge, compared shortly after
  always @(posedge clk) begin
    bit fire;
    fire = 0;
    if (rst) begin
      mArmed = 0; mLatch = 0; mRem = ratioOf(jam, modeSel, latchEn);
    end else if (modeSel[1:0] == 2'b00) begin
      mArmed = 0; mRem = ratioOf(jam, modeSel, latchEn);
    end else if (!mArmed) begin
      mArmed = 1; mRem = ratioOf(jam, modeSel, latchEn);
    end else if (mRem <= 1) begin
      fire = 1; mRem = ratioOf(jam, modeSel, latchEn);
    end else begin
      mRem = mRem - 1;
    end
    mPulse = fire;
    mLatch = rst ? 0 : (latchEn && (mLatch || (fire && modeSel != 3'b010)));
    #1;
    if (!done) begin
      checks++;
      if (divOut !== (mPulse || mLatch)) begin
        fails++;
        $display("FAIL %s: divOut=%b expected %b at %0t", tag, divOut, mPulse || mLatch, $time);
      end
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runMode(input string t, input logic [2:0] s, input logic [15:0] j,
                         input logic el, input int cycles);
    @(negedge clk);
    tag = "R6"; modeSel = 3'b000; jam = j; latchEn = el;
    hold(4);
    tag = t; modeSel = s;
    hold(cycles);
  endtask

  initial begin
    hold(5);
    // R9: reset state held low, then first pulse N+1 after release
    tag = "R9"; modeSel = 3'b110; jam = 16'h0007;
    rst = 1'b0;
    hold(30);

    // R1: divide-by-10, N = 1234
    runMode("R1", 3'b110, 16'h1234, 1'b0, 1300);
    // R4: jam change mid period, next reload uses N = 1239
    tag = "R4"; jam = 16'h1239;
    hold(2600);

    // R2: divide-by-2, t=1, d4=0 d3=1 d2=2 -> 2025
    runMode("R2", 3'b111, 16'h0123, 1'b0, 4100);

    // R3: divide-by-4 (67), divide-by-5 (29), divide-by-8 (191)
    runMode("R3", 3'b011, 16'h0163, 1'b0, 300);
    runMode("R3", 3'b101, 16'h0054, 1'b0, 200);
    runMode("R3", 3'b001, 16'h0237, 1'b0, 600);

    // R5: extended decade presets: divide-by-10 d2=15 -> 150, divide-by-8 max 21327
    runMode("R5", 3'b110, 16'h00F0, 1'b0, 500);
    runMode("R5", 3'b001, 16'hFFFF, 1'b0, 43000);

    // R6: long hold then release, N = 5 gives first pulse 6 clocks later
    @(negedge clk);
    tag = "R6"; modeSel = 3'b100; jam = 16'h0005;
    hold(10);
    modeSel = 3'b110;
    hold(30);

    // R7: latch in divide-by-5, N = 13
    runMode("R7", 3'b101, 16'h0023, 1'b1, 40);
    tag = "R7"; latchEn = 1'b0; hold(20);
    latchEn = 1'b1; hold(30);
    latchEn = 1'b0; hold(15);

    // R8: fixed 10000 ignoring jam, then latch-free divide-by-10 with N = 37
    runMode("R8", 3'b010, 16'hFFFF, 1'b0, 5000);
    tag = "R8"; jam = 16'h1234;
    hold(15100);
    runMode("R8", 3'b010, 16'h0037, 1'b1, 150);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule